// File: doc/BRIEF.md
# Tagged Content-Addressable Memory with Validity Control

This block is a small content-addressable memory. It holds DEPTH entries of WIDTH data bits. Each entry also carries a two-bit state tag with four values: empty, valid, skipped and random. The block takes 16-bit command words. One command family sets the state tag of one entry. The other compares every entry in a chosen state against a comparand register. A mask register can take part in the compare. The compare produces a hit flag and the lowest matching index.

The tag-setting command can target one of three entries:
- the entry at an internal address register, which then steps;
- an absolute address, supplied on the command cycle that follows, after which the address register steps from it;
- the entry reported by the last compare.

Entry data arrives through a separate write port. The same bus loads the comparand and the mask. Software can visit every valid entry in turn. It compares on the valid state, then moves the reported entry to another state, and repeats until the hit flag stays clear.

Top module: `vtag_cam`

## Requirements
- R1: While reset is high, on the next clock edge `addr_reg`, `match_addr`, `match_flag` and `addr_pending` become 0 and every tag becomes empty (00). The comparand, the mask and all entry data become 0.
- R2: The word `0x0400 | s` with s in 0..3 is the address-register form. It writes state s into the entry at `addr_reg`. On the same edge `addr_reg` steps by +1, or by −1 when `step_down` is 1. State codes are 00 empty, 01 valid, 10 skipped, 11 random.
- R3: The word `0x0C08 | s` with s in 0..3 is the absolute form, and it sets `addr_pending`. The next accepted command word is treated as an address, whatever its value, and its low ADDR_W bits select the entry. State s is written there. `addr_reg` becomes that address stepped by one in the `step_down` direction, and `addr_pending` clears.
- R4: The word `0x0410 | s` with s in 0..3 is the match-target form. It writes state s into the entry at `match_addr` only when `match_flag` is 1. In both cases `addr_reg` is left unchanged.
- R5: The compare word is `0x0500 | s` with s in 0..3. An entry matches when its tag equals s and its data equals the comparand in every compared bit. On the edge that accepts the command, `match_flag` and `match_addr` take the result.
- R6: When `mask_en` is 1, data bits where the mask register holds 1 are left out of the compare. When `mask_en` is 0, the mask register has no effect.
- R7: A compare on state 00 (empty) looks only at the tags, and every data bit is ignored.
- R8: `match_addr` reports the lowest-indexed matching entry. When nothing matches, `match_flag` is 0 and `match_addr` is 0.
- R9: Any other command word leaves tags, `addr_reg`, `addr_pending`, `match_flag` and `match_addr` unchanged. This covers:
  - state field bit 2 set;
  - a target code other than 000, 001 and 010;
  - the flag bit (bit 11) set with a target other than 001, or clear with target 001;
  - an unknown opcode.
- R10: `addr_reg` wraps modulo DEPTH in both step directions.
- R11: `wr_en` writes `wr_data` into the data of entry `wr_addr`, and leaves tags and `addr_reg` unchanged. `ld_comparand` and `ld_mask` load the comparand and mask registers from `wr_data`. Without `cmd_valid`, `addr_reg`, `addr_pending` and the match outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 16 | Command word, or the absolute address on the cycle after an absolute-form command |
| step_down | input | 1 | Address register step direction: 0 increments, 1 decrements |
| mask_en | input | 1 | Use the mask register during compares |
| wr_en | input | 1 | Write entry data |
| wr_addr | input | ADDR_W | Entry index for a data write |
| wr_data | input | WIDTH | Data for an entry, comparand or mask load |
| ld_comparand | input | 1 | Load the comparand register from wr_data |
| ld_mask | input | 1 | Load the mask register from wr_data |
| match_flag | output | 1 | Last compare found at least one match |
| match_addr | output | ADDR_W | Lowest matching index of the last compare |
| addr_reg | output | ADDR_W | Address register |
| addr_pending | output | 1 | Waiting for the absolute address word |

## Verification
The bench builds the block with its defaults: DEPTH 16 and WIDTH 64. A 4-bit address register reaches both wrap points within a handful of commands, starting from absolute addresses 0 and 15. Mask and data differences are placed on bits 0 and 63, so the outermost bit of the compare path at each end is exercised. Sixteen entries leave room for several entries in each state at once. That makes it possible to check the lowest-index priority and the tag-only empty compare, with valid, skipped and random entries present at the same time.

// File: rtl/vtag_cam_pkg.sv
package vtag_cam_pkg;

    localparam int CMD_W = 16;

    // Opcode fields of the command word
    localparam logic [3:0] HI_NIBBLE   = 4'h0;
    localparam logic [2:0] TAGSET_CODE = 3'b100;
    localparam logic [7:0] CMP_CODE    = 8'h05;

    // Target selectors for the tag-setting command
    localparam logic [2:0] TGT_AR  = 3'b000;
    localparam logic [2:0] TGT_ABS = 3'b001;
    localparam logic [2:0] TGT_HIT = 3'b010;

    typedef enum logic [1:0] {
        TAG_EMPTY = 2'b00,
        TAG_VALID = 2'b01,
        TAG_SKIP  = 2'b10,
        TAG_RAND  = 2'b11
    } tag_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TAG_AR,
        OP_TAG_HIT,
        OP_ARM_ABS,
        OP_CMP
    } op_e;

    typedef struct packed {
        op_e  op;
        tag_e tag;
    } dec_t;

    function automatic dec_t decode_word(input logic [CMD_W-1:0] w);
        dec_t d;
        d.op  = OP_NONE;
        d.tag = tag_e'(w[1:0]);
        if (w[15:12] == HI_NIBBLE && w[10:8] == TAGSET_CODE &&
            w[7:6] == 2'b00 && !w[2]) begin
            if (!w[11] && w[5:3] == TGT_AR)
                d.op = OP_TAG_AR;
            else if (!w[11] && w[5:3] == TGT_HIT)
                d.op = OP_TAG_HIT;
            else if (w[11] && w[5:3] == TGT_ABS)
                d.op = OP_ARM_ABS;
        end else if (w[15:8] == CMP_CODE && w[7:2] == 6'd0) begin
            d.op = OP_CMP;
        end
        return d;
    endfunction

endpackage

// File: rtl/vtag_cam_ctrl.sv
module vtag_cam_ctrl
    import vtag_cam_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             step_down,
    input  logic             match_flag,
    input  logic [AW-1:0]    match_addr,
    output logic             tag_we,
    output logic [AW-1:0]    tag_waddr,
    output tag_e             tag_wval,
    output logic             cmp_go,
    output tag_e             cmp_tag,
    output logic [AW-1:0]    addr_reg,
    output logic             addr_pending
);

    dec_t          dec;
    logic          pend_q;
    tag_e          pend_tag_q;
    logic [AW-1:0] ar_q;
    logic [AW-1:0] ar_base;
    logic [AW-1:0] ar_next;
    logic          ar_step;
    logic          pend_set;

    assign dec = decode_word(cmd_word);

    always_comb begin
        tag_we    = 1'b0;
        tag_waddr = ar_q;
        tag_wval  = dec.tag;
        cmp_go    = 1'b0;
        cmp_tag   = dec.tag;
        ar_step   = 1'b0;
        ar_base   = ar_q;
        pend_set  = 1'b0;
        if (cmd_valid) begin
            if (pend_q) begin
                // second cycle of the absolute form: word carries address
                tag_we    = 1'b1;
                tag_waddr = cmd_word[AW-1:0];
                tag_wval  = pend_tag_q;
                ar_base   = cmd_word[AW-1:0];
                ar_step   = 1'b1;
            end else begin
                case (dec.op)
                    OP_TAG_AR: begin
                        tag_we  = 1'b1;
                        ar_step = 1'b1;
                    end
                    OP_TAG_HIT: begin
                        tag_we    = match_flag;
                        tag_waddr = match_addr;
                    end
                    OP_ARM_ABS: pend_set = 1'b1;
                    OP_CMP:     cmp_go   = 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // DEPTH is a power of two, so natural wrap gives modulo stepping
    assign ar_next = step_down ? (ar_base - AW'(1)) : (ar_base + AW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q       <= '0;
            pend_q     <= 1'b0;
            pend_tag_q <= TAG_EMPTY;
        end else begin
            if (ar_step)
                ar_q <= ar_next;
            if (cmd_valid) begin
                if (pend_q) begin
                    pend_q <= 1'b0;
                end else if (pend_set) begin
                    pend_q     <= 1'b1;
                    pend_tag_q <= dec.tag;
                end
            end
        end
    end

    assign addr_reg     = ar_q;
    assign addr_pending = pend_q;

endmodule

// File: rtl/vtag_cam_array.sv
module vtag_cam_array
    import vtag_cam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ld_comparand,
    input  logic             ld_mask,
    input  logic             mask_en,
    input  logic             tag_we,
    input  logic [AW-1:0]    tag_waddr,
    input  tag_e             tag_wval,
    input  tag_e             cmp_tag,
    output logic [DEPTH-1:0] hit_vec
);

    logic [WIDTH-1:0] comparand_q;
    logic [WIDTH-1:0] mask_q;
    logic [WIDTH-1:0] care;
    logic             tag_only;

    always_ff @(posedge clk) begin
        if (rst) begin
            comparand_q <= '0;
            mask_q      <= '0;
        end else begin
            if (ld_comparand)
                comparand_q <= wr_data;
            if (ld_mask)
                mask_q <= wr_data;
        end
    end

    // a mask bit of 1 removes that data bit from the compare
    assign care     = mask_en ? ~mask_q : '1;
    assign tag_only = (cmp_tag == TAG_EMPTY);

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        tag_e             tag_q;
        logic [WIDTH-1:0] data_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q  <= TAG_EMPTY;
                data_q <= '0;
            end else begin
                if (tag_we && tag_waddr == AW'(i))
                    tag_q <= tag_wval;
                if (wr_en && wr_addr == AW'(i))
                    data_q <= wr_data;
            end
        end

        assign hit_vec[i] = (tag_q == cmp_tag) &&
                            (tag_only || (((data_q ^ comparand_q) & care) == '0));
    end

endmodule

// File: rtl/vtag_cam_prio.sv
module vtag_cam_prio #(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic [DEPTH-1:0] vec,
    output logic             any,
    output logic [AW-1:0]    idx
);

    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec[i])
                idx = AW'(i);
        end
    end

endmodule

// File: rtl/vtag_cam.sv
module vtag_cam
    import vtag_cam_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [15:0]       cmd_word,
    input  logic              step_down,
    input  logic              mask_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              ld_comparand,
    input  logic              ld_mask,
    output logic              match_flag,
    output logic [ADDR_W-1:0] match_addr,
    output logic [ADDR_W-1:0] addr_reg,
    output logic              addr_pending
);

    logic              tag_we;
    logic [ADDR_W-1:0] tag_waddr;
    tag_e              tag_wval;
    logic              cmp_go;
    tag_e              cmp_tag;
    logic [DEPTH-1:0]  hit_vec;
    logic              hit_any;
    logic [ADDR_W-1:0] hit_idx;

    vtag_cam_ctrl #(.AW(ADDR_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_word     (cmd_word),
        .step_down    (step_down),
        .match_flag   (match_flag),
        .match_addr   (match_addr),
        .tag_we       (tag_we),
        .tag_waddr    (tag_waddr),
        .tag_wval     (tag_wval),
        .cmp_go       (cmp_go),
        .cmp_tag      (cmp_tag),
        .addr_reg     (addr_reg),
        .addr_pending (addr_pending)
    );

    vtag_cam_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(ADDR_W)) u_array (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ld_comparand (ld_comparand),
        .ld_mask      (ld_mask),
        .mask_en      (mask_en),
        .tag_we       (tag_we),
        .tag_waddr    (tag_waddr),
        .tag_wval     (tag_wval),
        .cmp_tag      (cmp_tag),
        .hit_vec      (hit_vec)
    );

    vtag_cam_prio #(.DEPTH(DEPTH), .AW(ADDR_W)) u_prio (
        .vec (hit_vec),
        .any (hit_any),
        .idx (hit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            match_flag <= 1'b0;
            match_addr <= '0;
        end else if (cmp_go) begin
            match_flag <= hit_any;
            match_addr <= hit_idx;
        end
    end

endmodule

// File: rtl/vtag_cam_checker.sv
module vtag_cam_checker #(
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic [15:0]   cmd_word,
    input logic          step_down,
    input logic          match_flag,
    input logic [AW-1:0] match_addr,
    input logic [AW-1:0] addr_reg,
    input logic          addr_pending
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (addr_reg == '0 && match_addr == '0 && !match_flag && !addr_pending))
        else $error("reset state wrong");

    assert_ar_form_up_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !addr_pending && cmd_word[15:3] == 13'h0080 && !cmd_word[2] && !step_down)
        |=> addr_reg == $past(addr_reg) + AW'(1))
        else $error("address register did not step up");

    assert_ar_form_down_R10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !addr_pending && cmd_word[15:3] == 13'h0080 && !cmd_word[2] && step_down)
        |=> addr_reg == $past(addr_reg) - AW'(1))
        else $error("address register did not step down");

    assert_abs_arm_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !addr_pending && cmd_word[15:3] == 13'h0181 && !cmd_word[2])
        |=> addr_pending)
        else $error("absolute form did not arm");

    assert_abs_load_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && addr_pending && !step_down)
        |=> (!addr_pending && addr_reg == $past(cmd_word[AW-1:0]) + AW'(1)))
        else $error("absolute address not loaded and stepped");

    assert_hit_form_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !addr_pending && cmd_word[15:3] == 13'h0082) |=> $stable(addr_reg))
        else $error("match-target form moved the address register");

    assert_nomatch_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !match_flag |-> match_addr == '0)
        else $error("match address nonzero without a match");

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(addr_reg) && $stable(addr_pending) &&
                        $stable(match_flag) && $stable(match_addr)))
        else $error("state moved without a command");

endmodule

bind vtag_cam vtag_cam_checker #(.AW(ADDR_W)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_word     (cmd_word),
    .step_down    (step_down),
    .match_flag   (match_flag),
    .match_addr   (match_addr),
    .addr_reg     (addr_reg),
    .addr_pending (addr_pending)
);

// File: tb/vtag_cam_test.sv
module vtag_cam_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] KEY = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        step_down = 1'b0;
    logic        mask_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        ld_comparand = 1'b0;
    logic        ld_mask = 1'b0;
    logic        match_flag;
    logic [3:0]  match_addr;
    logic [3:0]  addr_reg;
    logic        addr_pending;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vtag_cam uut (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_word     (cmd_word),
        .step_down    (step_down),
        .mask_en      (mask_en),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .ld_comparand (ld_comparand),
        .ld_mask      (ld_mask),
        .match_flag   (match_flag),
        .match_addr   (match_addr),
        .addr_reg     (addr_reg),
        .addr_pending (addr_pending)
    );

    typedef struct packed {
        logic [15:0] word;
        logic        flag;
        logic [3:0]  addr;
        logic [3:0]  ar;
        logic        pend;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{16'h0501, 1'b1, 4'd3, 4'd13, 1'b0, 4'd5},  // R5: valid, data equal -> 3
        '{16'h0412, 1'b1, 4'd3, 4'd13, 1'b0, 4'd4},  // R4: entry 3 -> skipped
        '{16'h0501, 1'b1, 4'd7, 4'd13, 1'b0, 4'd8},  // R8: next lowest is 7
        '{16'h0412, 1'b1, 4'd7, 4'd13, 1'b0, 4'd4},  // R4: entry 7 -> skipped
        '{16'h0501, 1'b0, 4'd0, 4'd13, 1'b0, 4'd8},  // R8: none left
        '{16'h0412, 1'b0, 4'd0, 4'd13, 1'b0, 4'd4},  // R4: no match, no write
        '{16'h0502, 1'b1, 4'd3, 4'd13, 1'b0, 4'd5},  // R5: skipped with key
        '{16'h0500, 1'b1, 4'd0, 4'd13, 1'b0, 4'd7},  // R7: entry 0 empty, data ignored
        '{16'h0503, 1'b0, 4'd0, 4'd13, 1'b0, 4'd5},  // R5: no random entries
        '{16'h0418, 1'b0, 4'd0, 4'd13, 1'b0, 4'd9},  // R9: target 011
        '{16'h0405, 1'b0, 4'd0, 4'd13, 1'b0, 4'd9},  // R9: state bit 2 set
        '{16'h0C01, 1'b0, 4'd0, 4'd13, 1'b0, 4'd9},  // R9: flag with target 000
        '{16'h0504, 1'b0, 4'd0, 4'd13, 1'b0, 4'd9},  // R9: compare state bit 2
        '{16'h1234, 1'b0, 4'd0, 4'd13, 1'b0, 4'd9},  // R9: unknown opcode
        '{16'h0500, 1'b1, 4'd0, 4'd13, 1'b0, 4'd9},  // R9: tags untouched
        '{16'h0501, 1'b0, 4'd0, 4'd13, 1'b0, 4'd9}   // R9: still no valid key
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic write_entry(input logic [3:0] idx, input logic [63:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = idx;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_regs(input logic cmp, input logic msk, input logic [63:0] d);
        @(negedge clk);
        ld_comparand = cmp;
        ld_mask      = msk;
        wr_data      = d;
        @(negedge clk);
        ld_comparand = 1'b0;
        ld_mask      = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 flag", match_flag, 0);
        check("R1 addr", match_addr, 0);
        check("R1 ar", addr_reg, 0);
        check("R1 pend", addr_pending, 0);
        do_cmd(16'h0500);
        check("R1 empty tags flag", match_flag, 1);
        check("R1 empty tags addr", match_addr, 0);
        do_cmd(16'h0501);
        check("R8 no valid flag", match_flag, 0);
        check("R8 no valid addr", match_addr, 0);

        // R11 data and comparand loads
        write_entry(4'd3, KEY);
        write_entry(4'd7, KEY);
        write_entry(4'd9, KEY ^ 64'h1);
        write_entry(4'd12, KEY ^ 64'h8000_0000_0000_0000);
        load_regs(1'b1, 1'b0, KEY);
        check("R11 ar after writes", addr_reg, 0);

        // R3 absolute form
        do_cmd(16'h0C09);
        check("R3 pending set", addr_pending, 1);
        check("R3 ar held while pending", addr_reg, 0);
        do_cmd(16'h0003);
        check("R3 pending clear", addr_pending, 0);
        check("R3 ar stepped", addr_reg, 4);
        do_cmd(16'h0C09);
        do_cmd(16'hFFF7);
        check("R3 upper bits ignored", addr_reg, 8);
        // R2 address-register form
        do_cmd(16'h0402);
        check("R2 ar step 1", addr_reg, 9);
        do_cmd(16'h0401);
        check("R2 ar step 2", addr_reg, 10);
        do_cmd(16'h0C09);
        do_cmd(16'h000C);
        check("R3 ar after 12", addr_reg, 13);

        for (int i = 0; i < NV; i++) begin
            do_cmd(VECS[i].word);
            check($sformatf("R%0d vec%0d flag", VECS[i].req, i), match_flag, VECS[i].flag);
            check($sformatf("R%0d vec%0d addr", VECS[i].req, i), match_addr, VECS[i].addr);
            check($sformatf("R%0d vec%0d ar", VECS[i].req, i), addr_reg, VECS[i].ar);
            check($sformatf("R%0d vec%0d pend", VECS[i].req, i), addr_pending, VECS[i].pend);
        end

        // R6 masking: valid entries 9 (bit0 differs) and 12 (bit63 differs)
        load_regs(1'b0, 1'b1, 64'h8000_0000_0000_0001);
        do_cmd(16'h0501);
        check("R6 mask off flag", match_flag, 0);
        @(negedge clk) mask_en = 1'b1;
        do_cmd(16'h0501);
        check("R6 mask on flag", match_flag, 1);
        check("R6 mask on addr", match_addr, 9);
        load_regs(1'b0, 1'b1, 64'h1);
        do_cmd(16'h0501);
        check("R6 bit0 mask addr", match_addr, 9);
        load_regs(1'b0, 1'b1, 64'h8000_0000_0000_0000);
        do_cmd(16'h0501);
        check("R6 bit63 mask addr", match_addr, 12);
        load_regs(1'b0, 1'b1, 64'h8000_0000_0000_0001);

        // R10 wrap in both directions
        write_entry(4'd0, KEY);
        write_entry(4'd15, KEY);
        @(negedge clk) step_down = 1'b1;
        do_cmd(16'h0C0B);
        check("R3 pending random", addr_pending, 1);
        do_cmd(16'h0000);
        check("R10 wrap down", addr_reg, 15);
        do_cmd(16'h0403);
        check("R2 step down", addr_reg, 14);
        do_cmd(16'h0503);
        check("R10 random flag", match_flag, 1);
        check("R10 random addr", match_addr, 0);
        @(negedge clk) step_down = 1'b0;
        do_cmd(16'h0C08);
        do_cmd(16'h000F);
        check("R10 wrap up", addr_reg, 0);
        do_cmd(16'h0503);
        check("R10 entry 0 still random", match_addr, 0);

        // R11 data write leaves tags alone
        write_entry(4'd0, KEY ^ 64'h10);
        do_cmd(16'h0503);
        check("R11 changed data flag", match_flag, 0);
        check("R11 ar unchanged", addr_reg, 0);
        write_entry(4'd0, KEY);
        do_cmd(16'h0503);
        check("R11 tag kept flag", match_flag, 1);
        check("R11 tag kept addr", match_addr, 0);

        // R1 reset in the middle of the absolute form
        do_cmd(16'h0C09);
        check("R3 pending before reset", addr_pending, 1);
        @(negedge clk) rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1 pend cleared", addr_pending, 0);
        check("R1 flag cleared", match_flag, 0);
        check("R1 ar cleared", addr_reg, 0);
        do_cmd(16'h0503);
        check("R1 tags cleared", match_flag, 0);

        finish_run();
    end

endmodule